// File: doc/BRIEF.md
# Transform Frame Sequencing Controller

This block sits between a pair of sample buffers and a packet-oriented streaming transform engine that is reused in turn for several passes of one acquisition (two forward transforms, then an inverse). On a start command from the processor side it reads packed complex samples from the head of an input FIFO. It hands each sample to the engine's sink with valid, start-of-packet and end-of-packet markers, for a frame of exactly `FRAME_LEN` samples. The direction bit is latched once per frame.

On the result side it accepts the engine's output words and writes each one, one cycle later, into an output data FIFO. The block exponent that travels with each word goes to its own FIFO in the same cycle. It checks that the engine's packet markers bracket exactly one frame. A pair of 8-bit registers carries the command in and the busy, done and error state out.

Top module: `xform_frame_ctrl`

## Requirements
- R1: After reset the status register reads 0, and sink valid, input read request and both FIFO write requests are low.
- R2: A control write with bit 0 set while not busy sets busy (status bit 0) on the next cycle, clears done (bit 1) and error (bit 2), and latches control bit 1 as the direction (0 forward, 1 inverse), driven on the engine's inverse input.
- R3: Sink valid and input read request are asserted together, only while busy, the input FIFO is not empty, the engine is ready and fewer than `FRAME_LEN` samples of the current frame have been sent. No read happens while idle or after the frame is complete.
- R4: Start-of-packet accompanies valid on the first sample of a frame, and end-of-packet accompanies valid on the last. Valid is low in the cycle after end-of-packet.
- R5: Each 16-bit input word is split with the real part from bits 7:0 and the imaginary part from bits 15:8, both two's-complement bytes; sample values are -3, -1, 1, 3 (0xFD, 0xFF, 0x01, 0x03).
- R6: The direction output is held for the whole frame. A control write while busy, whether it carries start or a new direction, is ignored.
- R7: The engine's source is ready whenever the output FIFOs are not full. Each accepted result word appears on the output FIFO write port on the next cycle, packed real low byte and imaginary high byte, with its 6-bit exponent written to the exponent FIFO in the same cycle.
- R8: In the cycle the end-of-packet result word is written, done is set and busy clears. Done then holds until the next start.
- R9: Error is set when accepted result words do not form a packet that starts with start-of-packet and ends with end-of-packet on exactly the `FRAME_LEN`-th word. This covers an early end marker and a missing start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control value: bit 0 start, bit 1 inverse |
| status | output | 8 | Bit 0 busy, bit 1 done, bit 2 error, others 0 |
| in_empty | input | 1 | Input FIFO empty |
| in_q | input | 16 | Input FIFO head word (show-ahead) |
| in_rdreq | output | 1 | Input FIFO pop |
| snk_ready | input | 1 | Engine accepts a sample this cycle |
| snk_valid | output | 1 | Sample valid to engine |
| snk_sop | output | 1 | First sample of frame |
| snk_eop | output | 1 | Last sample of frame |
| snk_re | output | 8 | Sample real part |
| snk_im | output | 8 | Sample imaginary part |
| snk_inv | output | 1 | Direction: 0 forward, 1 inverse |
| src_valid | input | 1 | Engine result valid |
| src_sop | input | 1 | Engine result start marker |
| src_eop | input | 1 | Engine result end marker |
| src_re | input | 8 | Result real part |
| src_im | input | 8 | Result imaginary part |
| src_exp | input | 6 | Result block exponent |
| src_ready | output | 1 | Block accepts a result word |
| out_full | input | 1 | Output FIFOs full |
| out_wrreq | output | 1 | Output data FIFO write |
| out_data | output | 16 | Output data word |
| exp_wrreq | output | 1 | Exponent FIFO write |
| exp_data | output | 6 | Exponent value |

## Verification
The hardest situation to reach is a frame boundary that meets back-pressure and mid-frame traffic at once. The input FIFO holds a word that belongs to the next frame, the engine drops ready at random, and a control write arrives in mid-frame. Only then can a sample duplicated or taken across the boundary show up. The bench gets there by pre-loading samples before the start command. It feeds the rest with random gaps against a randomly toggling ready, and writes start-with-inverse in mid-frame. It then pushes one extra word after the last sample, and that word must stay in the FIFO until the next start. Malformed result packets, one with an early end marker and one with no start marker, are driven under random FIFO-full stalls to reach the error status.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    typedef struct packed {
        logic busy;
        logic done;
        logic err;
        logic inv;
    } xfc_ctl_t;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_INV_BIT   = 1;

endpackage

// File: rtl/xfc_sink_drv.sv
module xfc_sink_drv #(
    parameter int FRAME_LEN = 32768,
    parameter int SAMP_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  clr,
    input  logic                  in_empty,
    input  logic [2*SAMP_W-1:0]   in_q,
    input  logic                  snk_ready,
    output logic                  in_rdreq,
    output logic                  snk_valid,
    output logic                  snk_sop,
    output logic                  snk_eop,
    output logic [SAMP_W-1:0]     snk_re,
    output logic [SAMP_W-1:0]     snk_im
);
    localparam int CW = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } sink_st_t;

    sink_st_t st_d, st_q;
    logic     take;

    always_comb begin
        take = run && (st_q.cnt < CW'(FRAME_LEN)) && !in_empty && snk_ready;
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (take) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_rdreq  = take;
    assign snk_valid = take;
    assign snk_sop   = take && (st_q.cnt == '0);
    assign snk_eop   = take && (st_q.cnt == CW'(FRAME_LEN - 1));
    assign snk_re    = in_q[SAMP_W-1:0];
    assign snk_im    = in_q[2*SAMP_W-1:SAMP_W];

    p_take_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        snk_valid |-> (snk_ready && !in_empty && run));

    p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(FRAME_LEN));

    p_eop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snk_eop |=> !snk_valid);

endmodule

// File: rtl/xfc_src_cap.sv
module xfc_src_cap #(
    parameter int FRAME_LEN = 32768,
    parameter int SAMP_W    = 8,
    parameter int EXP_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  src_valid,
    input  logic                  src_sop,
    input  logic                  src_eop,
    input  logic [SAMP_W-1:0]     src_re,
    input  logic [SAMP_W-1:0]     src_im,
    input  logic [EXP_W-1:0]      src_exp,
    input  logic                  out_full,
    output logic                  src_ready,
    output logic                  out_wrreq,
    output logic [2*SAMP_W-1:0]   out_data,
    output logic                  exp_wrreq,
    output logic [EXP_W-1:0]      exp_data,
    output logic                  acc_eop,
    output logic                  acc_bad
);
    localparam int IW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

    typedef struct packed {
        logic                wr;
        logic [2*SAMP_W-1:0] data;
        logic [EXP_W-1:0]    expv;
        logic                inpkt;
        logic [IW-1:0]       cnt;
    } cap_st_t;

    cap_st_t       st_d, st_q;
    logic          acc;
    logic [IW-1:0] idx;
    logic          last;

    always_comb begin
        acc     = src_valid && !out_full;
        idx     = src_sop ? '0 : st_q.cnt;
        last    = (idx == IW'(FRAME_LEN - 1));
        acc_eop = acc && src_eop;
        acc_bad = acc && ((src_sop && st_q.inpkt) ||
                          (!src_sop && !st_q.inpkt) ||
                          (src_eop != last));
        st_d      = st_q;
        st_d.wr   = acc;
        st_d.data = acc ? {src_im, src_re} : st_q.data;
        st_d.expv = acc ? src_exp : st_q.expv;
        if (clr) begin
            st_d.inpkt = 1'b0;
            st_d.cnt   = '0;
        end else if (acc) begin
            if (src_eop) begin
                st_d.inpkt = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.inpkt = 1'b1;
                st_d.cnt   = idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_ready = !out_full;
    assign out_wrreq = st_q.wr;
    assign out_data  = st_q.data;
    assign exp_wrreq = st_q.wr;
    assign exp_data  = st_q.expv;

    p_wr_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> (out_wrreq && exp_wrreq));

    p_wr_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> (out_data == $past({src_im, src_re})) &&
                                     (exp_data == $past(src_exp)));

    p_pkt_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && src_eop && !clr) |=> !st_q.inpkt);

endmodule

// File: rtl/xform_frame_ctrl.sv
module xform_frame_ctrl
    import xfc_pkg::*;
#(
    parameter int FRAME_LEN = 32768,
    parameter int SAMP_W    = 8,
    parameter int EXP_W     = 6,
    parameter int REG_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr,
    input  logic [REG_W-1:0]      ctrl_data,
    output logic [REG_W-1:0]      status,
    input  logic                  in_empty,
    input  logic [2*SAMP_W-1:0]   in_q,
    output logic                  in_rdreq,
    input  logic                  snk_ready,
    output logic                  snk_valid,
    output logic                  snk_sop,
    output logic                  snk_eop,
    output logic [SAMP_W-1:0]     snk_re,
    output logic [SAMP_W-1:0]     snk_im,
    output logic                  snk_inv,
    input  logic                  src_valid,
    input  logic                  src_sop,
    input  logic                  src_eop,
    input  logic [SAMP_W-1:0]     src_re,
    input  logic [SAMP_W-1:0]     src_im,
    input  logic [EXP_W-1:0]      src_exp,
    output logic                  src_ready,
    input  logic                  out_full,
    output logic                  out_wrreq,
    output logic [2*SAMP_W-1:0]   out_data,
    output logic                  exp_wrreq,
    output logic [EXP_W-1:0]      exp_data
);
    xfc_ctl_t ctl_d, ctl_q;
    logic     start;
    logic     acc_eop;
    logic     acc_bad;
    logic     ctrl_unused;

    assign ctrl_unused = ^ctrl_data[REG_W-1:2];

    always_comb begin
        start = ctrl_wr && ctrl_data[CTRL_START_BIT] && !ctl_q.busy;
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.busy = 1'b1;
            ctl_d.done = 1'b0;
            ctl_d.err  = 1'b0;
            ctl_d.inv  = ctrl_data[CTRL_INV_BIT];
        end else if (ctl_q.busy) begin
            if (acc_bad) begin
                ctl_d.err = 1'b1;
            end
            if (acc_eop) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign status  = {{(REG_W-3){1'b0}}, ctl_q.err, ctl_q.done, ctl_q.busy};
    assign snk_inv = ctl_q.inv;

    xfc_sink_drv #(
        .FRAME_LEN (FRAME_LEN),
        .SAMP_W    (SAMP_W)
    ) sink_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctl_q.busy),
        .clr       (start),
        .in_empty  (in_empty),
        .in_q      (in_q),
        .snk_ready (snk_ready),
        .in_rdreq  (in_rdreq),
        .snk_valid (snk_valid),
        .snk_sop   (snk_sop),
        .snk_eop   (snk_eop),
        .snk_re    (snk_re),
        .snk_im    (snk_im)
    );

    xfc_src_cap #(
        .FRAME_LEN (FRAME_LEN),
        .SAMP_W    (SAMP_W),
        .EXP_W     (EXP_W)
    ) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .src_valid (src_valid),
        .src_sop   (src_sop),
        .src_eop   (src_eop),
        .src_re    (src_re),
        .src_im    (src_im),
        .src_exp   (src_exp),
        .out_full  (out_full),
        .src_ready (src_ready),
        .out_wrreq (out_wrreq),
        .out_data  (out_data),
        .exp_wrreq (exp_wrreq),
        .exp_data  (exp_data),
        .acc_eop   (acc_eop),
        .acc_bad   (acc_bad)
    );

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (status[0] && !status[1] && !status[2]));

    p_inv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && $past(ctl_q.busy)) |-> $stable(snk_inv));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> !status[0]);

    p_busy_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_rdreq |-> status[0]);

endmodule

// File: tb/xform_frame_ctrl_tb_top.sv
module xform_frame_ctrl_tb_top;
    localparam int LEN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_data = '0;
    logic [7:0]  status;
    logic        in_empty;
    logic [15:0] in_q;
    logic        in_rdreq;
    logic        snk_ready = 1'b1;
    logic        snk_valid, snk_sop, snk_eop, snk_inv;
    logic [7:0]  snk_re, snk_im;
    logic        src_valid = 1'b0, src_sop = 1'b0, src_eop = 1'b0;
    logic [7:0]  src_re = '0, src_im = '0;
    logic [5:0]  src_exp = '0;
    logic        src_ready;
    logic        out_full = 1'b0;
    logic        out_wrreq, exp_wrreq;
    logic [15:0] out_data;
    logic [5:0]  exp_data;

    logic [15:0] fifo_mem [0:255];
    int          wp = 0;
    int          rp = 0;
    int          gsc = 0;
    int          sc = 0;
    bit          cur_mode = 1'b0;
    bit          frame_open = 1'b0;
    bit          rdy_rand = 1'b0;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    assign in_empty = (rp == wp);
    assign in_q     = fifo_mem[rp[7:0]];

    always @(posedge clk) begin
        if (in_rdreq) rp <= rp + 1;
    end

    xform_frame_ctrl #(.FRAME_LEN(LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .status(status), .in_empty(in_empty), .in_q(in_q), .in_rdreq(in_rdreq),
        .snk_ready(snk_ready), .snk_valid(snk_valid), .snk_sop(snk_sop),
        .snk_eop(snk_eop), .snk_re(snk_re), .snk_im(snk_im), .snk_inv(snk_inv),
        .src_valid(src_valid), .src_sop(src_sop), .src_eop(src_eop),
        .src_re(src_re), .src_im(src_im), .src_exp(src_exp),
        .src_ready(src_ready), .out_full(out_full), .out_wrreq(out_wrreq),
        .out_data(out_data), .exp_wrreq(exp_wrreq), .exp_data(exp_data)
    );

    function automatic logic [7:0] legal_val(input int code);
        return 8'(2 * (code % 4) - 3);
    endfunction

    function automatic logic [15:0] rand_word();
        logic [7:0] re, im;
        re = legal_val(int'($urandom % 4));
        im = legal_val(int'($urandom % 4));
        return {im, re};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (snk_valid) begin
                check(in_rdreq, "R3 rdreq with valid", 32'(in_rdreq), 1);
                check(snk_ready && !in_empty, "R3 valid gating", 32'({snk_ready, in_empty}), 32'h2);
                check(frame_open && sc < LEN, "R3 sample count", 32'(sc), LEN);
                check({snk_im, snk_re} == fifo_mem[gsc], "R5 unpack", 32'({snk_im, snk_re}),
                      32'(fifo_mem[gsc]));
                check(snk_sop == (sc == 0), "R4 sop", 32'(snk_sop), 32'(sc == 0));
                check(snk_eop == (sc == LEN - 1), "R4 eop", 32'(snk_eop), 32'(sc == LEN - 1));
                check(snk_inv == cur_mode, "R6 mode", 32'(snk_inv), 32'(cur_mode));
                sc++;
                gsc++;
            end else if (in_rdreq) begin
                check(1'b0, "R3 rdreq without valid", 1, 0);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk); #2;
            snk_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    task automatic push(input logic [15:0] w);
        fifo_mem[wp[7:0]] = w;
        wp++;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            push(rand_word());
            repeat ($urandom % 3) @(posedge clk);
        end
    endtask

    task automatic start_frame(input bit inv);
        @(posedge clk); #2;
        sc = 0;
        cur_mode = inv;
        frame_open = 1'b1;
        ctrl_wr = 1'b1;
        ctrl_data = {6'b0, inv, 1'b1};
        @(posedge clk); #2;
        ctrl_wr = 1'b0;
        ctrl_data = '0;
        check(status == 8'h01, "R2 busy after start", 32'(status), 1);
        check(snk_inv == inv, "R2 mode latched", 32'(snk_inv), 32'(inv));
    endtask

    task automatic wait_drain();
        int lim = 0;
        while (sc < LEN && lim < 2000) begin
            @(posedge clk);
            lim++;
        end
        @(posedge clk); #2;
    endtask

    task automatic send_word(input bit sop, input bit eop, input logic [15:0] w,
                             input logic [5:0] e);
        bit acc = 1'b0;
        while (!acc) begin
            src_valid = 1'b1;
            src_sop = sop;
            src_eop = eop;
            src_re = w[7:0];
            src_im = w[15:8];
            src_exp = e;
            out_full = (($urandom % 4) == 0);
            acc = !out_full;
            @(posedge clk);
            @(negedge clk);
            check(out_wrreq == acc && exp_wrreq == acc, "R7 write strobe",
                  32'({out_wrreq, exp_wrreq}), 32'({acc, acc}));
            check(src_ready == !out_full, "R7 ready", 32'(src_ready), 32'(!out_full));
            if (acc) begin
                check(out_data == w, "R7 data", 32'(out_data), 32'(w));
                check(exp_data == e, "R7 exponent", 32'(exp_data), 32'(e));
            end
            #1;
            src_valid = 1'b0;
            out_full = 1'b0;
            @(posedge clk); #2;
        end
    endtask

    task automatic send_frame(input int eop_at, input bit with_sop);
        for (int i = 0; i <= eop_at; i++) begin
            send_word(with_sop && i == 0, i == eop_at, rand_word(), 6'($urandom % 64));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        process::self().srandom(32'd12345);
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 8'h00, "R1 status", 32'(status), 0);
        check(!snk_valid && !in_rdreq, "R1 sink idle", 32'({snk_valid, in_rdreq}), 0);
        check(!out_wrreq && !exp_wrreq, "R1 writes idle", 32'({out_wrreq, exp_wrreq}), 0);

        // idle: preloaded words must not be read (R3)
        @(posedge clk); #2;
        for (int i = 0; i < 3; i++) push(rand_word());
        repeat (5) @(posedge clk);
        #2;
        check(rp == 0, "R3 no read while idle", 32'(rp), 0);

        // forward frame with ready stalls and mid-frame command (R2 R6)
        rdy_rand = 1'b1;
        start_frame(1'b0);
        push_n(6);
        @(posedge clk); #2;
        ctrl_wr = 1'b1;
        ctrl_data = 8'h03;
        @(posedge clk); #2;
        ctrl_wr = 1'b0;
        ctrl_data = '0;
        check(status == 8'h01, "R6 start ignored while busy", 32'(status), 1);
        check(snk_inv == 1'b0, "R6 mode change ignored", 32'(snk_inv), 0);
        push_n(LEN - 9);
        wait_drain();
        check(sc == LEN, "R3 frame length", 32'(sc), LEN);

        // extra word must stay in FIFO (R3)
        push(rand_word());
        repeat (6) @(posedge clk);
        #2;
        check(wp - rp == 1, "R3 no read past frame", 32'(wp - rp), 1);

        send_frame(LEN - 1, 1'b1);
        check(status == 8'h02, "R8 done set, busy clear", 32'(status), 2);
        repeat (3) @(posedge clk);
        #2;
        check(status == 8'h02, "R8 done holds, R9 no error", 32'(status), 2);

        // inverse frame, early end marker (R2 R9)
        start_frame(1'b1);
        push_n(LEN - 1);
        wait_drain();
        send_frame(4, 1'b1);
        check(status == 8'h06, "R9 early eop error", 32'(status), 6);

        // forward frame, missing start marker (R9)
        start_frame(1'b0);
        push_n(LEN);
        wait_drain();
        send_frame(LEN - 1, 1'b0);
        check(status == 8'h06, "R9 missing sop error", 32'(status), 6);

        // clean inverse frame with full ready (R2 clears error)
        rdy_rand = 1'b0;
        start_frame(1'b1);
        check(status[2] == 1'b0, "R2 error cleared", 32'(status[2]), 0);
        push_n(LEN);
        wait_drain();
        check(sc == LEN, "R4 full frame", 32'(sc), LEN);
        send_frame(LEN - 1, 1'b1);
        check(status == 8'h02, "R8 clean done", 32'(status), 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule